// File: doc/BRIEF.md
# I2C Transfer-Length Controller

This block keeps track of how many data bytes remain in an I2C message and turns that number into bus decisions. It sits next to a byte shift engine. Software loads a 16-bit count. Each data byte that the shift engine completes lowers the count by one. Address bytes do not change it, and the count never goes below zero. When the count reaches zero, the block does three things:

- It picks the end-of-count acknowledge value instead of the normal one.
- It raises a sticky count flag, which feeds an aggregate interrupt flag and an interrupt line.
- In host mode, it decides what happens on the 9th falling SCL edge: either an automatic Stop, or a clock stretch that waits for software to request a Restart.

A state machine with four states handles the host end-of-count decision:

- `EOC_RUN` is the normal state. It moves to `EOC_STOP` or to `EOC_HOLD` on the 9th falling edge in host mode while the count is zero.
- `EOC_STOP` lasts one cycle and drives the Stop request. It then returns to `EOC_RUN`.
- `EOC_HOLD` drives the stretch request. It stays there until the start bit is set, then moves to `EOC_RESTART`.
- `EOC_RESTART` lasts one cycle and drives the Restart pulse. It clears the start bit and returns to `EOC_RUN`.

A separate load guard records whether each software load landed outside a safe window.

Top module: `i2c_xfer_len_ctrl`

## Requirements
- R1: A cycle with `byte_done`=1 and `is_addr`=0 and no load lowers `count` by one on the next clock. A byte with `is_addr`=1 leaves `count` unchanged.
- R2: With `count`=0, a data byte completion leaves `count` at 0 and does not set `cnt_flag`.
- R3: `ld_en`=1 writes `ld_val` into `count` on the next clock. If a data byte completes in the same cycle, the load wins and no decrement is applied.
- R4: `cnt_flag` sets on the clock where a decrement takes `count` from 1 to 0. It stays set until a `cnt_flag_clr` strobe. If a set and a clear come in the same cycle, the set wins.
- R5: A decrement to zero while `ie_cnt`=1 also sets `agg_flag`. `irq` equals `agg_flag` AND `ie_glob`.
- R6: No port can write `agg_flag`. Once set, it stays set while `cnt_flag` or any bit of `aux_flags` is set. It clears on the clock after all of them are clear.
- R7: `ack_val` equals `ack_norm` while `count` is nonzero and equals `ack_eoc` while `count` is zero.
- R8: Consider host mode (`host_mode`=1) with `count`=0 and `restart_en`=0. A cycle with `scl_fall`=1 and `bit_idx`=9 makes `stop_req` high for exactly one cycle, on the following cycle. With `bit_idx`=8, or with a nonzero count, `stop_req` stays low.
- R9: Consider host mode with `count`=0 and `restart_en`=1. The 9th falling edge raises `stretch_req`, which stays high until the start bit is set (`start_set` strobe, visible on `start_bit`). On the next cycle `stretch_req` drops and `restart_req` pulses for one cycle. After that pulse, `start_bit` reads 0.
- R10: In client mode (`host_mode`=0), the 9th falling edge with `count`=0 raises none of `stop_req`, `stretch_req` or `restart_req`.
- R11: Each load sets `unsafe_ld` to 1 in either of two cases. The first is a load in the same cycle as a hazard edge: `scl_fall` with `bit_idx`=8 while `is_rx`=1, or with `bit_idx`=9 while `is_rx`=0. The second is a load outside the safe window. In host mode the safe window is `host_data_rdy` or `bus_free`. In client mode it is `client_stretch`=0 or `stop_seen`=1. Otherwise the load sets `unsafe_ld` to 0.
- R12: After reset, `count`=0 and all flags, requests, `start_bit` and `unsafe_ld` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ld_en | input | 1 | Software load strobe for the count |
| ld_val | input | 16 | Value to load |
| byte_done | input | 1 | Shift engine finished a byte |
| is_addr | input | 1 | Finished byte was an address byte |
| is_rx | input | 1 | 1 = receiving, 0 = transmitting |
| host_mode | input | 1 | 1 = host, 0 = client |
| scl_fall | input | 1 | SCL falling-edge strobe |
| bit_idx | input | 4 | Index (1..9) of that falling edge within the byte |
| ack_norm | input | 1 | Acknowledge value while count is nonzero |
| ack_eoc | input | 1 | Acknowledge value once count is zero |
| restart_en | input | 1 | Hold for Restart instead of an automatic Stop |
| start_set | input | 1 | Software strobe setting the start bit |
| ie_cnt | input | 1 | Count interrupt enable |
| ie_glob | input | 1 | Global interrupt enable |
| cnt_flag_clr | input | 1 | Software clear strobe for the count flag |
| aux_flags | input | 2 | Other interrupt flags feeding the aggregate flag |
| client_stretch | input | 1 | Client is stretching the clock |
| stop_seen | input | 1 | Client has received a Stop |
| host_data_rdy | input | 1 | Host data-ready status |
| bus_free | input | 1 | Bus-free status |
| count | output | 16 | Remaining data bytes |
| ack_val | output | 1 | Acknowledge value to drive |
| stop_req | output | 1 | One-cycle Stop request |
| restart_req | output | 1 | One-cycle Restart request |
| stretch_req | output | 1 | Clock-stretch request |
| start_bit | output | 1 | Start bit state |
| cnt_flag | output | 1 | Sticky count flag |
| agg_flag | output | 1 | Aggregate interrupt flag |
| irq | output | 1 | Interrupt output |
| unsafe_ld | output | 1 | Last load was outside a safe window |

## Verification
The counting path is driven from a table of load values and byte counts. The table covers:

- a partial countdown, which checks a plain decrement;
- an exact countdown to zero, which checks flag setting;
- an overrun past zero, which checks saturation;
- a load of zero followed by bytes, which shows that saturation raises no flag;
- a load of all ones, which checks width handling.

Directed patterns then probe the end-of-count decisions:

- The 9th falling edge is applied with the count zero and with it nonzero, which separates a Stop that is gated by the count from one that is not.
- The 8th and 9th edges are both applied, which separates an edge decode that is too loose from a correct one.
- Host and client modes are both tried, which separates a mode-qualified decision from an unqualified one.
- Restart enable is tried both set and clear, which separates a plain Stop from a stretch followed by a Restart.

Load-guard patterns vary direction, edge index and each safe-window input, so the guard must use the right edge for each direction.

// File: rtl/xfer_len_pkg.sv
package xfer_len_pkg;
    typedef enum logic [1:0] {
        EOC_RUN     = 2'd0,
        EOC_STOP    = 2'd1,
        EOC_HOLD    = 2'd2,
        EOC_RESTART = 2'd3
    } eoc_state_t;

    localparam int unsigned ACK_EDGE_IDX  = 9;
    localparam int unsigned RX_LAST_IDX   = 8;
endpackage

// File: rtl/xfer_count_unit.sv
module xfer_count_unit #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             byte_done,
    input  logic             is_addr,
    output logic [CNT_W-1:0] cnt,
    output logic             cnt_zero,
    output logic             hit_zero
);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CNT_NONE = '0;

    logic data_step;

    assign cnt_zero  = (cnt == CNT_NONE);
    assign data_step = byte_done && !is_addr && !ld_en && !cnt_zero;
    assign hit_zero  = data_step && (cnt == CNT_ONE);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= CNT_NONE;
        end else if (ld_en) begin
            cnt <= ld_val;
        end else if (data_step) begin
            cnt <= cnt - CNT_ONE;
        end
    end

    // R2
    count_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_zero && !ld_en) |=> cnt_zero);

    // R1
    addr_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_en && (!byte_done || is_addr)) |=> $stable(cnt));

    // R3
    load_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_en |=> (cnt == $past(ld_val)));
endmodule

// File: rtl/xfer_irq_unit.sv
module xfer_irq_unit #(
    parameter int unsigned AUX_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_zero,
    input  logic             flag_clr,
    input  logic             ie_cnt,
    input  logic             ie_glob,
    input  logic [AUX_N-1:0] aux_flags,
    output logic             cnt_flag,
    output logic             agg_flag,
    output logic             irq
);
    logic cf_nxt;
    logic agg_nxt;
    logic any_aux;

    assign any_aux = |aux_flags;
    assign cf_nxt  = hit_zero || (cnt_flag && !flag_clr);
    assign agg_nxt = (hit_zero && ie_cnt) || (agg_flag && (cf_nxt || any_aux));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_flag <= 1'b0;
            agg_flag <= 1'b0;
        end else begin
            cnt_flag <= cf_nxt;
            agg_flag <= agg_nxt;
        end
    end

    assign irq = agg_flag && ie_glob;

    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_flag && !flag_clr) |=> cnt_flag);

    // R6
    agg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (agg_flag && any_aux) |=> agg_flag);
endmodule

// File: rtl/xfer_load_guard.sv
module xfer_load_guard #(
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic             host_mode,
    input  logic             is_rx,
    input  logic             scl_fall,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             client_stretch,
    input  logic             stop_seen,
    input  logic             host_data_rdy,
    input  logic             bus_free,
    output logic             unsafe_ld
);
    import xfer_len_pkg::*;

    localparam logic [IDX_W-1:0] RX_EDGE = IDX_W'(RX_LAST_IDX);
    localparam logic [IDX_W-1:0] TX_EDGE = IDX_W'(ACK_EDGE_IDX);

    logic hazard_edge;
    logic in_window;

    assign hazard_edge = scl_fall &&
        ((is_rx && bit_idx == RX_EDGE) || (!is_rx && bit_idx == TX_EDGE));
    assign in_window = host_mode ? (host_data_rdy || bus_free)
                                 : (!client_stretch || stop_seen);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            unsafe_ld <= 1'b0;
        end else if (ld_en) begin
            unsafe_ld <= hazard_edge || !in_window;
        end
    end

    // R11
    guard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ld_en |=> $stable(unsafe_ld));
endmodule

// File: rtl/xfer_eoc_fsm.sv
module xfer_eoc_fsm #(
    parameter int unsigned IDX_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             host_mode,
    input  logic             cnt_zero,
    input  logic             restart_en,
    input  logic             scl_fall,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             start_set,
    output logic             stop_req,
    output logic             restart_req,
    output logic             stretch_req,
    output logic             start_bit
);
    import xfer_len_pkg::*;

    localparam logic [IDX_W-1:0] ACK_EDGE = IDX_W'(ACK_EDGE_IDX);

    eoc_state_t state_q;
    eoc_state_t state_d;
    logic       eoc_edge;

    assign eoc_edge = host_mode && cnt_zero && scl_fall && (bit_idx == ACK_EDGE);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EOC_RUN:     if (eoc_edge) state_d = restart_en ? EOC_HOLD : EOC_STOP;
            EOC_STOP:    state_d = EOC_RUN;
            EOC_HOLD:    if (start_bit) state_d = EOC_RESTART;
            EOC_RESTART: state_d = EOC_RUN;
            default:     state_d = EOC_RUN;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q   <= EOC_RUN;
            start_bit <= 1'b0;
        end else begin
            state_q   <= state_d;
            start_bit <= start_set || (start_bit && (state_q != EOC_RESTART));
        end
    end

    always_comb begin
        stop_req    = 1'b0;
        restart_req = 1'b0;
        stretch_req = 1'b0;
        unique case (state_q)
            EOC_RUN:     ;
            EOC_STOP:    stop_req    = 1'b1;
            EOC_HOLD:    stretch_req = 1'b1;
            EOC_RESTART: restart_req = 1'b1;
            default:     ;
        endcase
    end

    // R8
    stop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        stop_req |=> !stop_req);

    // R9
    restart_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        restart_req |=> !restart_req);

    // R9
    stretch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (stretch_req && !start_bit) |=> stretch_req);

    // R9
    one_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({stop_req, restart_req, stretch_req}));
endmodule

// File: rtl/i2c_xfer_len_ctrl.sv
module i2c_xfer_len_ctrl #(
    parameter int unsigned CNT_W = 16,
    parameter int unsigned IDX_W = 4,
    parameter int unsigned AUX_N = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ld_en,
    input  logic [CNT_W-1:0] ld_val,
    input  logic             byte_done,
    input  logic             is_addr,
    input  logic             is_rx,
    input  logic             host_mode,
    input  logic             scl_fall,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic             ack_norm,
    input  logic             ack_eoc,
    input  logic             restart_en,
    input  logic             start_set,
    input  logic             ie_cnt,
    input  logic             ie_glob,
    input  logic             cnt_flag_clr,
    input  logic [AUX_N-1:0] aux_flags,
    input  logic             client_stretch,
    input  logic             stop_seen,
    input  logic             host_data_rdy,
    input  logic             bus_free,
    output logic [CNT_W-1:0] count,
    output logic             ack_val,
    output logic             stop_req,
    output logic             restart_req,
    output logic             stretch_req,
    output logic             start_bit,
    output logic             cnt_flag,
    output logic             agg_flag,
    output logic             irq,
    output logic             unsafe_ld
);
    logic cnt_zero;
    logic hit_zero;

    xfer_count_unit #(.CNT_W(CNT_W)) u_count (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_val(ld_val),
        .byte_done(byte_done), .is_addr(is_addr),
        .cnt(count), .cnt_zero(cnt_zero), .hit_zero(hit_zero)
    );

    xfer_irq_unit #(.AUX_N(AUX_N)) u_irq (
        .clk(clk), .rst_n(rst_n), .hit_zero(hit_zero), .flag_clr(cnt_flag_clr),
        .ie_cnt(ie_cnt), .ie_glob(ie_glob), .aux_flags(aux_flags),
        .cnt_flag(cnt_flag), .agg_flag(agg_flag), .irq(irq)
    );

    xfer_load_guard #(.IDX_W(IDX_W)) u_guard (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .host_mode(host_mode),
        .is_rx(is_rx), .scl_fall(scl_fall), .bit_idx(bit_idx),
        .client_stretch(client_stretch), .stop_seen(stop_seen),
        .host_data_rdy(host_data_rdy), .bus_free(bus_free),
        .unsafe_ld(unsafe_ld)
    );

    xfer_eoc_fsm #(.IDX_W(IDX_W)) u_eoc (
        .clk(clk), .rst_n(rst_n), .host_mode(host_mode), .cnt_zero(cnt_zero),
        .restart_en(restart_en), .scl_fall(scl_fall), .bit_idx(bit_idx),
        .start_set(start_set), .stop_req(stop_req), .restart_req(restart_req),
        .stretch_req(stretch_req), .start_bit(start_bit)
    );

    assign ack_val = cnt_zero ? ack_eoc : ack_norm;

    // R7
    ack_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (count != '0) |-> (ack_val == ack_norm));

    // R5
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (agg_flag && ie_glob));
endmodule

// File: tb/i2c_xfer_len_ctrl_bench.sv
module i2c_xfer_len_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ld_en = 0, byte_done = 0, is_addr = 0, is_rx = 0, host_mode = 1;
    logic [15:0] ld_val = '0;
    logic        scl_fall = 0;
    logic [3:0]  bit_idx = '0;
    logic        ack_norm = 1, ack_eoc = 0, restart_en = 0, start_set = 0;
    logic        ie_cnt = 0, ie_glob = 0, cnt_flag_clr = 0;
    logic [1:0]  aux_flags = '0;
    logic        client_stretch = 0, stop_seen = 0, host_data_rdy = 1, bus_free = 0;
    logic [15:0] count;
    logic        ack_val, stop_req, restart_req, stretch_req, start_bit;
    logic        cnt_flag, agg_flag, irq, unsafe_ld;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    i2c_xfer_len_ctrl u_i2c_xfer_len_ctrl (
        .clk(clk), .rst_n(rst_n), .ld_en(ld_en), .ld_val(ld_val),
        .byte_done(byte_done), .is_addr(is_addr), .is_rx(is_rx),
        .host_mode(host_mode), .scl_fall(scl_fall), .bit_idx(bit_idx),
        .ack_norm(ack_norm), .ack_eoc(ack_eoc), .restart_en(restart_en),
        .start_set(start_set), .ie_cnt(ie_cnt), .ie_glob(ie_glob),
        .cnt_flag_clr(cnt_flag_clr), .aux_flags(aux_flags),
        .client_stretch(client_stretch), .stop_seen(stop_seen),
        .host_data_rdy(host_data_rdy), .bus_free(bus_free),
        .count(count), .ack_val(ack_val), .stop_req(stop_req),
        .restart_req(restart_req), .stretch_req(stretch_req),
        .start_bit(start_bit), .cnt_flag(cnt_flag), .agg_flag(agg_flag),
        .irq(irq), .unsafe_ld(unsafe_ld)
    );

    // {load value, data bytes, expected count, expected flag}
    localparam logic [40:0] VEC [6] = '{
        {16'd5,      8'd3, 16'd2,      1'b0},
        {16'd3,      8'd3, 16'd0,      1'b1},
        {16'd2,      8'd5, 16'd0,      1'b1},
        {16'd0,      8'd2, 16'd0,      1'b0},
        {16'hFFFF,   8'd1, 16'hFFFE,   1'b0},
        {16'd1,      8'd1, 16'd0,      1'b1}
    };

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic load(input logic [15:0] v);
        ld_en = 1; ld_val = v; cyc(); ld_en = 0;
    endtask

    task automatic data_byte(input logic addr);
        byte_done = 1; is_addr = addr; cyc(); byte_done = 0; is_addr = 0;
    endtask

    task automatic edge_at(input logic [3:0] idx);
        scl_fall = 1; bit_idx = idx; cyc(); scl_fall = 0; bit_idx = 0;
    endtask

    task automatic clear_flag();
        cnt_flag_clr = 1; cyc(); cnt_flag_clr = 0;
    endtask

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            finish_run();
        end
    end

    initial begin
        repeat (3) cyc();
        // R12 reset state
        chk("R12 count", 32'(count), 0);
        chk("R12 flags", {28'd0, cnt_flag, agg_flag, irq, unsafe_ld}, 0);
        chk("R12 requests", {28'd0, stop_req, restart_req, stretch_req, start_bit}, 0);
        rst_n = 1;
        cyc();

        // Table walk: R1 R2 R4 R7
        for (int i = 0; i < 6; i++) begin
            clear_flag();
            load(VEC[i][40:25]);
            for (int b = 0; b < int'(VEC[i][24:17]); b++) data_byte(1'b0);
            chk("R1/R2 count", 32'(count), 32'(VEC[i][16:1]));
            chk("R4 cnt_flag", 32'(cnt_flag), 32'(VEC[i][0]));
            chk("R7 ack_val", 32'(ack_val), 32'(VEC[i][16:1] != 0));
        end

        // R1 address byte ignored
        load(16'd4);
        data_byte(1'b1);
        chk("R1 addr byte", 32'(count), 4);
        // R3 load wins over same-cycle decrement
        ld_en = 1; ld_val = 16'd7; byte_done = 1; cyc();
        ld_en = 0; byte_done = 0;
        chk("R3 load wins", 32'(count), 7);
        // R7 end-of-count ack value
        load(16'd0);
        ack_norm = 0; ack_eoc = 1; cyc();
        chk("R7 ack eoc", 32'(ack_val), 1);
        ack_norm = 1; ack_eoc = 0;

        // R4 set wins over clear
        clear_flag();
        load(16'd1);
        byte_done = 1; cnt_flag_clr = 1; cyc(); byte_done = 0; cnt_flag_clr = 0;
        chk("R4 set wins", 32'(cnt_flag), 1);
        clear_flag();
        chk("R4 cleared", 32'(cnt_flag), 0);

        // R5 aggregate and irq
        ie_cnt = 1; ie_glob = 0;
        load(16'd1);
        data_byte(1'b0);
        chk("R5 agg set", 32'(agg_flag), 1);
        chk("R5 irq gated", 32'(irq), 0);
        ie_glob = 1; cyc();
        chk("R5 irq on", 32'(irq), 1);
        // R6 hold while aux flag set
        aux_flags = 2'b10;
        clear_flag();
        cyc();
        chk("R6 agg held", 32'(agg_flag), 1);
        aux_flags = 2'b00; cyc();
        chk("R6 agg cleared", 32'(agg_flag), 0);
        chk("R6 irq off", 32'(irq), 0);
        ie_cnt = 0; ie_glob = 0;

        // R8 automatic stop
        restart_en = 0;
        load(16'd0);
        edge_at(4'd8);
        chk("R8 no stop at edge 8", 32'(stop_req), 0);
        edge_at(4'd9);
        chk("R8 stop pulse", 32'(stop_req), 1);
        chk("R8 no stretch", 32'(stretch_req), 0);
        cyc();
        chk("R8 stop one cycle", 32'(stop_req), 0);
        load(16'd2);
        edge_at(4'd9);
        chk("R8 no stop nonzero", 32'(stop_req), 0);

        // R9 restart path
        restart_en = 1;
        load(16'd0);
        edge_at(4'd9);
        chk("R9 stretch", 32'(stretch_req), 1);
        chk("R9 no stop", 32'(stop_req), 0);
        repeat (3) cyc();
        chk("R9 stretch held", 32'(stretch_req), 1);
        start_set = 1; cyc(); start_set = 0;
        chk("R9 start bit", 32'(start_bit), 1);
        cyc();
        chk("R9 restart pulse", 32'(restart_req), 1);
        chk("R9 stretch released", 32'(stretch_req), 0);
        cyc();
        chk("R9 restart one cycle", 32'(restart_req), 0);
        chk("R9 start self-clear", 32'(start_bit), 0);

        // R10 client mode ignores end-of-count edge
        host_mode = 0;
        edge_at(4'd9);
        chk("R10 client quiet", {29'd0, stop_req, restart_req, stretch_req}, 0);
        restart_en = 0;
        edge_at(4'd9);
        chk("R10 client no stop", 32'(stop_req), 0);

        // R11 load guard, client mode
        client_stretch = 0; stop_seen = 0; load(16'd3);
        chk("R11 client idle safe", 32'(unsafe_ld), 0);
        client_stretch = 1; load(16'd3);
        chk("R11 client stretching", 32'(unsafe_ld), 1);
        stop_seen = 1; load(16'd3);
        chk("R11 client after stop", 32'(unsafe_ld), 0);
        client_stretch = 0; stop_seen = 0;
        is_rx = 0; ld_en = 1; ld_val = 16'd3; scl_fall = 1; bit_idx = 4'd9; cyc();
        ld_en = 0; scl_fall = 0; bit_idx = 0;
        chk("R11 tx 9th edge", 32'(unsafe_ld), 1);
        // R11 host mode
        host_mode = 1; host_data_rdy = 0; bus_free = 0; load(16'd3);
        chk("R11 host busy", 32'(unsafe_ld), 1);
        bus_free = 1; load(16'd3);
        chk("R11 host bus free", 32'(unsafe_ld), 0);
        bus_free = 0; host_data_rdy = 1;
        is_rx = 1; ld_en = 1; scl_fall = 1; bit_idx = 4'd8; cyc();
        ld_en = 0; scl_fall = 0; bit_idx = 0;
        chk("R11 rx 8th edge", 32'(unsafe_ld), 1);
        is_rx = 0; ld_en = 1; scl_fall = 1; bit_idx = 4'd8; cyc();
        ld_en = 0; scl_fall = 0; bit_idx = 0;
        chk("R11 tx 8th edge safe", 32'(unsafe_ld), 0);

        finish_run();
    end
endmodule